// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers thirteen level-sensitive interrupt requests, numbered 1 to 13, and tells the processor which one to service. Each source owns an 8-bit control byte. Its low five bits are a combined level and priority value, bits 4:2 of that value are the interrupt level sent to the processor, and bit 7 chooses between an automatic vector and a vector taken from a register.

A 16-bit mask can block any source. A read-only pending view shows the live request lines. In every cycle the controller picks the strongest unmasked request. It then registers a 3-bit level and an 8-bit vector number for the processor. Software reaches the control bytes, the mask, the pending view and three vector registers through a byte-wide register port. Writes take effect at the clock edge. Reads are combinational.

Top module: `vec_intc`

## Requirements
- R1: The pending view follows `irq_i` bits 13:1 with no delay. Bits 0, 15 and 14 read 0. Pending is read at 0x3A (bits 15:8) and 0x3B (bits 7:0). Writes to these two addresses change nothing.
- R2: A source whose mask bit is 1 is never selected. The mask is read and written at 0x36 (bits 15:8) and 0x37 (bits 7:0).
- R3: Among the unmasked pending sources, the one with the largest control[4:0] wins. When two are equal, the lower-numbered source wins.
- R4: If the winning control[4:0] is below 4, or no source is active, both the level and the vector are 0. A winning value of exactly 4 is presented.
- R5: The presented level equals control[4:2] of the winning source.
- R6: If control bit 7 of the winner is 1, the vector is 24 plus the level.
- R7: If control bit 7 of the winner is 0, the vector depends on the source. Source 8 takes the register at 0x42. Source 12 takes the register at 0x70. Source 13 takes the register at 0x71. Every other source gives 0x0F.
- R8: After reset the control bytes for sources 1 to 13 are 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x1C, 0x80, 0x80, 0x80, 0x00 and 0x00. The mask is 0x3FFE, all three vector registers are 0x0F, and the outputs are 0.
- R9: The control byte of source n is at address 0x13+n. Every writable register reads back the last value written to it. Any unmapped address reads 0.
- R10: The level and the vector are registered. They reflect the inputs and the register contents of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Request lines. Bit n belongs to source n. Bits 0, 15 and 14 are unused |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address, shared by reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| level_o | output | 3 | Registered interrupt level, 0 when idle |
| vector_o | output | 8 | Registered vector number, 0 when idle |

## Verification
The bench builds the block with its default parameters: thirteen sources, the base address 0x14 for the control bytes, a threshold of 4 and an automatic-vector base of 24. These values place the tie between sources 7 and 8 and the boundary values 3 and 4 within reach of directed cases. The same holds for the three sources that have their own vector registers. A random phase follows, with irregular requests and register writes. In this phase the behavioural model and the design are compared every cycle on the output pair and on the read data, so updates to the mask and the control bytes in the middle of a run are checked against the one-cycle output latency.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef logic [7:0] byte_t;

  // power-on control byte for a source
  function automatic byte_t ctrl_reset_val(int unsigned src);
    if (src >= 1 && src <= 7) return byte_t'(src * 4);
    else if (src == 8)        return 8'h1C;
    else if (src >= 9 && src <= 11) return 8'h80;
    else                      return 8'h00;
  endfunction
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC       = 13,
  parameter int unsigned REG_W       = 16,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned CTRL_BASE   = 'h14,
  parameter int unsigned MASK_ADDR   = 'h36,
  parameter int unsigned PEND_ADDR   = 'h3A,
  parameter int unsigned WVEC_ADDR   = 'h42,
  parameter int unsigned UVEC0_ADDR  = 'h70,
  parameter int unsigned UVEC1_ADDR  = 'h71,
  parameter logic [15:0] MASK_RST    = 16'h3FFE,
  parameter logic [7:0]  VEC_RST     = 8'h0F
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [7:0]             wdata_i,
  input  logic [REG_W-1:0]       pend_i,
  output logic [7:0]             rdata_o,
  output logic [N_SRC:1][7:0]    ctrl_o,
  output logic [REG_W-1:0]       mask_o,
  output logic [7:0]             wvec_o,
  output logic [7:0]             uvec0_o,
  output logic [7:0]             uvec1_o
);
  localparam logic [ADDR_W-1:0] MASK_HI = ADDR_W'(MASK_ADDR);
  localparam logic [ADDR_W-1:0] MASK_LO = ADDR_W'(MASK_ADDR + 1);
  localparam logic [ADDR_W-1:0] PEND_HI = ADDR_W'(PEND_ADDR);
  localparam logic [ADDR_W-1:0] PEND_LO = ADDR_W'(PEND_ADDR + 1);
  localparam logic [ADDR_W-1:0] WVEC_A  = ADDR_W'(WVEC_ADDR);
  localparam logic [ADDR_W-1:0] UVEC0_A = ADDR_W'(UVEC0_ADDR);
  localparam logic [ADDR_W-1:0] UVEC1_A = ADDR_W'(UVEC1_ADDR);

  logic [N_SRC:1][7:0] ctrl_q;
  logic [REG_W-1:0]    mask_q;
  logic [7:0]          wvec_q, uvec0_q, uvec1_q;

  for (genvar g = 1; g <= N_SRC; g++) begin : g_ctrl
    localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(CTRL_BASE + g - 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      ctrl_q[g] <= ctrl_reset_val(g);
      else if (we_i && addr_i == MY_A)  ctrl_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= MASK_RST;
      wvec_q  <= VEC_RST;
      uvec0_q <= VEC_RST;
      uvec1_q <= VEC_RST;
    end else if (we_i) begin
      if (addr_i == MASK_HI) mask_q[15:8] <= wdata_i;
      if (addr_i == MASK_LO) mask_q[7:0]  <= wdata_i;
      if (addr_i == WVEC_A)  wvec_q       <= wdata_i;
      if (addr_i == UVEC0_A) uvec0_q      <= wdata_i;
      if (addr_i == UVEC1_A) uvec1_q      <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 1; i <= N_SRC; i++)
      if (addr_i == ADDR_W'(CTRL_BASE + i - 1)) rdata_o = ctrl_q[i];
    if (addr_i == MASK_HI) rdata_o = mask_q[15:8];
    if (addr_i == MASK_LO) rdata_o = mask_q[7:0];
    if (addr_i == PEND_HI) rdata_o = pend_i[15:8];
    if (addr_i == PEND_LO) rdata_o = pend_i[7:0];
    if (addr_i == WVEC_A)  rdata_o = wvec_q;
    if (addr_i == UVEC0_A) rdata_o = uvec0_q;
    if (addr_i == UVEC1_A) rdata_o = uvec1_q;
  end

  assign ctrl_o  = ctrl_q;
  assign mask_o  = mask_q;
  assign wvec_o  = wvec_q;
  assign uvec0_o = uvec0_q;
  assign uvec1_o = uvec1_q;
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
  parameter int unsigned N_SRC   = 13,
  parameter int unsigned PRI_W   = 5,
  parameter int unsigned MIN_PRI = 4,
  localparam int unsigned IDX_W  = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC:1]       active_i,
  input  logic [N_SRC:1][7:0]  ctrl_i,
  output logic                 valid_o,
  output logic [IDX_W-1:0]     win_idx_o,
  output logic [7:0]           win_ctrl_o
);
  logic [PRI_W-1:0] best_pri;

  // strict compare keeps the lower index on a tie
  always_comb begin
    best_pri   = '0;
    win_idx_o  = '0;
    win_ctrl_o = '0;
    for (int i = 1; i <= N_SRC; i++) begin
      if (active_i[i] && ctrl_i[i][PRI_W-1:0] > best_pri) begin
        best_pri   = ctrl_i[i][PRI_W-1:0];
        win_idx_o  = IDX_W'(i);
        win_ctrl_o = ctrl_i[i];
      end
    end
    valid_o = best_pri >= PRI_W'(MIN_PRI);
  end
endmodule

// File: rtl/intc_vec.sv
module intc_vec #(
  parameter int unsigned N_SRC     = 13,
  parameter int unsigned AUTO_BASE = 24,
  parameter int unsigned SRC_WDOG  = 8,
  parameter int unsigned SRC_UART0 = 12,
  parameter int unsigned SRC_UART1 = 13,
  parameter logic [7:0]  VEC_NONE  = 8'h0F,
  localparam int unsigned IDX_W    = $clog2(N_SRC + 1)
) (
  input  logic             valid_i,
  input  logic [IDX_W-1:0] win_idx_i,
  input  logic [7:0]       win_ctrl_i,
  input  logic [7:0]       wvec_i,
  input  logic [7:0]       uvec0_i,
  input  logic [7:0]       uvec1_i,
  output logic [2:0]       level_o,
  output logic [7:0]       vector_o
);
  always_comb begin
    level_o  = '0;
    vector_o = '0;
    if (valid_i) begin
      level_o = win_ctrl_i[4:2];
      if (win_ctrl_i[7])                          vector_o = 8'(AUTO_BASE) + {5'b0, level_o};
      else if (win_idx_i == IDX_W'(SRC_WDOG))     vector_o = wvec_i;
      else if (win_idx_i == IDX_W'(SRC_UART0))    vector_o = uvec0_i;
      else if (win_idx_i == IDX_W'(SRC_UART1))    vector_o = uvec1_i;
      else                                        vector_o = VEC_NONE;
    end
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC     = 13,
  parameter int unsigned REG_W     = 16,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned MIN_PRI   = 4,
  parameter int unsigned AUTO_BASE = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  irq_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [2:0]        level_o,
  output logic [7:0]        vector_o
);
  localparam int unsigned IDX_W = $clog2(N_SRC + 1);

  logic [REG_W-1:0]    pend_w, mask_w;
  logic [N_SRC:1][7:0] ctrl_w;
  logic [N_SRC:1]      active_w;
  logic [7:0]          wvec_w, uvec0_w, uvec1_w, win_ctrl_w, vec_d;
  logic [IDX_W-1:0]    win_idx_w;
  logic                valid_w;
  logic [2:0]          lvl_d;

  always_comb begin
    pend_w = '0;
    pend_w[N_SRC:1] = irq_i[N_SRC:1];
  end
  assign active_w = pend_w[N_SRC:1] & ~mask_w[N_SRC:1];

  intc_regs #(.N_SRC(N_SRC), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .pend_i(pend_w), .rdata_o, .ctrl_o(ctrl_w), .mask_o(mask_w),
    .wvec_o(wvec_w), .uvec0_o(uvec0_w), .uvec1_o(uvec1_w)
  );

  intc_arb #(.N_SRC(N_SRC), .MIN_PRI(MIN_PRI)) u_arb (
    .active_i(active_w), .ctrl_i(ctrl_w), .valid_o(valid_w),
    .win_idx_o(win_idx_w), .win_ctrl_o(win_ctrl_w)
  );

  intc_vec #(.N_SRC(N_SRC), .AUTO_BASE(AUTO_BASE)) u_vec (
    .valid_i(valid_w), .win_idx_i(win_idx_w), .win_ctrl_i(win_ctrl_w),
    .wvec_i(wvec_w), .uvec0_i(uvec0_w), .uvec1_i(uvec1_w),
    .level_o(lvl_d), .vector_o(vec_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o  <= '0;
      vector_o <= '0;
    end else begin
      level_o  <= lvl_d;
      vector_o <= vec_d;
    end
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] irq_i,
  input logic        we_i,
  input logic [7:0]  addr_i,
  input logic [7:0]  rdata_o,
  input logic [2:0]  level_o,
  input logic [7:0]  vector_o,
  input logic [15:0] mask_w
);
  // R4: idle level comes with an idle vector
  assert_idle_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o == 3'd0 |-> vector_o == 8'd0);

  // R2: nothing unmasked and pending -> idle next cycle
  assert_masked_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i[13:1] & ~mask_w[13:1]) == 13'd0 |=> (level_o == 3'd0 && vector_o == 8'd0));

  // R1: unused pending bits read zero
  assert_pend_hi_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == 8'h3A |-> rdata_o[7:6] == 2'b00);
  assert_pend_lo_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == 8'h3B |-> rdata_o[0] == 1'b0);

  // R10: quiet inputs and no writes keep the outputs steady
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(we_i) && irq_i == $past(irq_i)) |=> $stable({level_o, vector_o}));
endmodule

bind vec_intc intc_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .we_i(we_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .level_o(level_o), .vector_o(vector_o), .mask_w(mask_w)
);

// File: tb/sim_vec_intc.sv
module sim_vec_intc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] irq_i = '0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [2:0]  level_o;
  logic [7:0]  vector_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0]  m_ctrl [1:13];
  logic [15:0] m_mask;
  logic [7:0]  m_wvec, m_u0, m_u1;
  logic [10:0] exp_out = '0;
  string       prev_tag = "R8";

  always #4 clk_i = ~clk_i;

  vec_intc u0 (.*);

  function automatic logic [10:0] ref_out(logic [15:0] irq);
    int best = 0, bi = 0;
    logic [7:0] v;
    logic [2:0] l;
    for (int i = 1; i <= 13; i++)
      if (irq[i] && !m_mask[i] && int'(m_ctrl[i] & 8'h1F) > best) begin
        best = int'(m_ctrl[i] & 8'h1F);
        bi = i;
      end
    if (best < 4) return '0;
    l = m_ctrl[bi][4:2];
    if (m_ctrl[bi][7]) v = 8'(24 + int'(l));
    else if (bi == 8)  v = m_wvec;
    else if (bi == 12) v = m_u0;
    else if (bi == 13) v = m_u1;
    else               v = 8'h0F;
    return {l, v};
  endfunction

  function automatic logic [7:0] ref_rd(logic [7:0] a, logic [15:0] irq);
    logic [15:0] p = {2'b00, irq[13:1], 1'b0};
    if (a >= 8'h14 && a <= 8'h20) return m_ctrl[int'(a) - 'h13];
    case (a)
      8'h36: return m_mask[15:8];
      8'h37: return m_mask[7:0];
      8'h3A: return p[15:8];
      8'h3B: return p[7:0];
      8'h42: return m_wvec;
      8'h70: return m_u0;
      8'h71: return m_u1;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    logic [7:0] rv [1:13] = '{8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C,
                              8'h1C, 8'h80, 8'h80, 8'h80, 8'h00, 8'h00};
    for (int i = 1; i <= 13; i++) m_ctrl[i] = rv[i];
    m_mask = 16'h3FFE;
    m_wvec = 8'h0F; m_u0 = 8'h0F; m_u1 = 8'h0F;
  endtask

  // one cycle: check previous outputs, drive, check read data, update model
  task automatic cyc(logic [15:0] irq, logic we, logic [7:0] a, logic [7:0] d, string tag);
    @(negedge clk_i);
    check({prev_tag, " out"}, {21'b0, level_o, vector_o}, {21'b0, exp_out});
    irq_i = irq; we_i = we; addr_i = a; wdata_i = d;
    #1;
    check({tag, " rd"}, {24'b0, rdata_o}, {24'b0, ref_rd(a, irq)});
    exp_out = ref_out(irq);
    if (we) begin
      if (a >= 8'h14 && a <= 8'h20) m_ctrl[int'(a) - 'h13] = d;
      else if (a == 8'h36) m_mask[15:8] = d;
      else if (a == 8'h37) m_mask[7:0] = d;
      else if (a == 8'h42) m_wvec = d;
      else if (a == 8'h70) m_u0 = d;
      else if (a == 8'h71) m_u1 = d;
    end
    prev_tag = tag;
  endtask

  task automatic wr(logic [15:0] irq, logic [7:0] a, logic [7:0] d, string tag);
    cyc(irq, 1'b1, a, d, tag);
  endtask

  task automatic idle(logic [15:0] irq, logic [7:0] a, int n, string tag);
    for (int k = 0; k < n; k++) cyc(irq, 1'b0, a, 8'h00, tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R8: reset contents and idle outputs
    for (int a = 'h14; a <= 'h20; a++) idle('0, 8'(a), 1, "R8");
    idle('0, 8'h36, 1, "R8"); idle('0, 8'h37, 1, "R8");
    idle('0, 8'h42, 1, "R8"); idle('0, 8'h70, 1, "R8"); idle('0, 8'h71, 1, "R8");
    // R1: pending view, unused bits, write ignored
    idle(16'hFFFF, 8'h3A, 1, "R1"); idle(16'hFFFF, 8'h3B, 1, "R1");
    wr(16'h0000, 8'h3A, 8'hFF, "R1"); wr(16'h0000, 8'h3B, 8'hFF, "R1");
    idle(16'h2AAA, 8'h3A, 1, "R1"); idle(16'h2AAA, 8'h3B, 1, "R1");
    // R9: unmask all, unmapped reads
    wr(16'hFFFF, 8'h36, 8'h00, "R9"); wr(16'hFFFF, 8'h37, 8'h00, "R9");
    idle(16'hFFFF, 8'h36, 1, "R9"); idle(16'hFFFF, 8'h55, 1, "R9");
    // R3: sources 7 and 8 tie at 0x1C; source 7 wins -> level 7, vector 0x0F (R7)
    idle(16'hFFFF, 8'h00, 3, "R3");
    // R7: source 8 uses its own vector register
    wr(16'h0100, 8'h42, 8'h40, "R7"); idle(16'h0100, 8'h42, 3, "R7");
    // R4: value 4 presented, value 3 suppressed
    idle(16'h0002, 8'h14, 3, "R4");
    wr(16'h0002, 8'h14, 8'h03, "R4"); idle(16'h0002, 8'h14, 3, "R4");
    // R6: autovector on source 12, value 0x14 -> level 5, vector 29
    wr(16'h1000, 8'h1F, 8'h94, "R6"); idle(16'h1000, 8'h1F, 3, "R6");
    // R7: sources 12 and 13 use their vector registers
    wr(16'h1000, 8'h1F, 8'h10, "R7"); wr(16'h1000, 8'h70, 8'h66, "R7");
    idle(16'h1000, 8'h70, 3, "R7");
    wr(16'h2000, 8'h20, 8'h0C, "R7"); wr(16'h2000, 8'h71, 8'h77, "R7");
    idle(16'h2000, 8'h71, 3, "R7");
    // R5: level follows bits 4:2 with a higher source
    wr(16'h3000, 8'h20, 8'h1B, "R5"); idle(16'h3000, 8'h20, 3, "R5");
    // R2: mask source 13, source 12 takes over; then mask both
    wr(16'h3000, 8'h36, 8'h20, "R2"); idle(16'h3000, 8'h36, 3, "R2");
    wr(16'h3000, 8'h36, 8'h30, "R2"); idle(16'h3000, 8'h36, 3, "R2");
    // R10: random requests and writes, compared every cycle
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] addrs [0:5] = '{8'h14, 8'h36, 8'h37, 8'h42, 8'h70, 8'h71};
      logic [7:0] a;
      logic [7:0] d = 8'($urandom);
      int pick = int'($urandom_range(0, 5));
      a = (pick == 0) ? 8'(8'h14 + $urandom_range(0, 12)) : addrs[pick];
      if (pick == 1 || pick == 2) d = d & 8'($urandom);
      cyc(16'($urandom), ($urandom_range(0, 3) == 0), a, d, "R10");
    end
    idle('0, 8'h00, 2, "R10");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule